// File: doc/BRIEF.md
# Banked Sorted Priority Queue

This block keeps up to `NUM_BANKS * BANK_DEPTH` tagged entries in ascending priority order and always hands out the smallest priority first. The storage is split into small banks. Each bank is a sorted array. Taken in bank index order, the non-empty banks cover priority intervals that follow one another and do not overlap. A register table holds the lowest and the highest priority stored in each bank.

On an insert, the table is searched to find the one bank whose interval must take the new priority. Only that bank compares the new priority with all of its entries at once and opens a gap for it. When the chosen bank is already full, entries ripple across bank borders toward the nearest bank that still has room. This ripple goes forward or backward, so an insert is refused only when the whole queue is full. A pop takes the head of the lowest non-empty bank.

Every operation takes one clock cycle. The results of a pop and the reject flag of an insert are registered and appear in the cycle after the request. A scheduler computes each entry's priority upstream. It pushes the priority with a small tag and pops whenever the link can send.

Top module: `pifo_banked`

## Requirements
- R1: After reset the queue is empty: `empty_o`=1, `full_o`=0, `pop_valid_o`=0, `pop_empty_o`=0 and `ins_reject_o`=0.
- R2: A pop on a non-empty queue sets `pop_valid_o`=1 in the next cycle, with the smallest stored priority on `pop_prio_o` and its tag on `pop_tag_o`. Successive pops therefore return entries in nondecreasing priority order.
- R3: Entries with equal priority leave in the order they arrived. A new entry is placed after all stored entries of the same priority.
- R4: A pop on an empty queue gives `pop_empty_o`=1, `pop_valid_o`=0 and zero on `pop_prio_o`/`pop_tag_o` in the next cycle. It leaves the queue empty.
- R5: The capacity is `NUM_BANKS*BANK_DEPTH` entries, and `full_o`=1 exactly when that many are stored. An insert while full gives `ins_reject_o`=1 in the next cycle and leaves the stored contents unchanged.
- R6: An insert whose target bank is full is still accepted when any other bank has room. Entries overflow across bank borders, forward or backward, and the global order is kept.
- R7: When insert and pop are requested in the same cycle, the pop is served. The insert is rejected (`ins_reject_o`=1 next cycle) and is not stored.
- R8: An insert on a non-full queue without a pop is accepted (`ins_reject_o`=0 next cycle). `empty_o` falls once the first entry is stored.
- R9: A priority smaller than every stored priority becomes the head, and the next pop returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_valid_i | input | 1 | Insert request this cycle |
| ins_prio_i | input | PRIO_W | Priority of the new entry, smaller leaves first |
| ins_tag_i | input | TAG_W | Tag carried with the new entry |
| pop_i | input | 1 | Pop request this cycle |
| ins_reject_o | output | 1 | Insert of the previous cycle was refused |
| pop_valid_o | output | 1 | Pop of the previous cycle returned an entry |
| pop_prio_o | output | PRIO_W | Priority of the popped entry, zero when none |
| pop_tag_o | output | TAG_W | Tag of the popped entry, zero when none |
| pop_empty_o | output | 1 | Pop of the previous cycle found the queue empty |
| empty_o | output | 1 | No entry stored |
| full_o | output | 1 | All entries occupied |

## Verification
The bench fills the queue with scattered priorities so that most inserts land in the middle of a full bank. A design that lost the tail on a forward ripple, or that refused such an insert, would return fewer entries or the wrong ones when drained. It then drains the front banks and appends large priorities, which pushes the ripple backward. A design that only overflows forward would reject these inserts even though space exists. Runs of equal priorities check that a wrong compare (`<` against `<=`) would reorder tags. Collisions, pops on an empty queue and inserts while full check that none of these changes the stored set.

// File: rtl/pifo_pkg.sv
// Shared types for the banked sorted queue.
// Assumes: nothing beyond SystemVerilog 2017.
package pifo_pkg;
    // Operation a single bank applies at the next clock edge.
    typedef enum logic [2:0] {
        BOP_HOLD,       // keep contents
        BOP_INS,        // open a gap at pos, store item, count + 1
        BOP_INS_DROPT,  // as BOP_INS on a full bank, last slot falls out
        BOP_INS_DROPH,  // full bank: slots below pos move up, item lands at pos-1, head falls out
        BOP_POP         // remove the head, count - 1
    } bank_op_e;
endpackage

// File: rtl/pifo_bank.sv
// One sorted bank of DEPTH entries {prio, tag}, priority in the upper bits.
// Compares a probe priority with all valid slots in parallel and applies the
// operation chosen by the controller. Assumes the controller never inserts
// into a bank beyond its capacity and never pops an empty bank.
module pifo_bank
    import pifo_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int PRIO_W = 16,
    parameter int TAG_W  = 8,
    localparam int EW    = PRIO_W + TAG_W,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bank_op_e          op_i,
    input  logic [CW-1:0]     pos_i,
    input  logic [EW-1:0]     item_i,
    input  logic [PRIO_W-1:0] probe_i,
    output logic [CW-1:0]     le_cnt_o,
    output logic [CW-1:0]     cnt_o,
    output logic [EW-1:0]     head_o,
    output logic [EW-1:0]     tail_o,
    output logic [CW-1:0]     nxt_cnt_o,
    output logic [PRIO_W-1:0] nxt_min_o,
    output logic [PRIO_W-1:0] nxt_max_o
);
    logic [DEPTH-1:0][EW-1:0] slot_q, slot_d;
    logic [CW-1:0]            cnt_q, cnt_d;

    // Parallel compare: number of valid slots whose priority is <= probe.
    always_comb begin
        le_cnt_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (CW'(i) < cnt_q && slot_q[i][EW-1 -: PRIO_W] <= probe_i)
                le_cnt_o = le_cnt_o + CW'(1);
        end
    end

    // Head and last valid slot for the neighbouring banks.
    always_comb begin
        head_o = slot_q[0];
        tail_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (CW'(i + 1) == cnt_q) tail_o = slot_q[i];
        end
    end

    // Next contents of the bank for the requested operation.
    always_comb begin
        slot_d = slot_q;
        cnt_d  = cnt_q;
        unique case (op_i)
            BOP_INS, BOP_INS_DROPT: begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (CW'(i) == pos_i)     slot_d[i] = item_i;
                    else if (CW'(i) > pos_i) slot_d[i] = slot_q[(i == 0) ? 0 : i - 1];
                end
                if (op_i == BOP_INS) cnt_d = cnt_q + CW'(1);
            end
            BOP_INS_DROPH: begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (CW'(i + 1) < pos_i)       slot_d[i] = slot_q[(i == DEPTH - 1) ? i : i + 1];
                    else if (CW'(i + 1) == pos_i) slot_d[i] = item_i;
                end
            end
            BOP_POP: begin
                for (int i = 0; i < DEPTH; i++)
                    slot_d[i] = slot_q[(i == DEPTH - 1) ? i : i + 1];
                cnt_d = cnt_q - CW'(1);
            end
            default: ;
        endcase
    end

    // Bounds of the next contents, for the range table.
    always_comb begin
        nxt_cnt_o = cnt_d;
        nxt_min_o = slot_d[0][EW-1 -: PRIO_W];
        nxt_max_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (CW'(i + 1) == cnt_d) nxt_max_o = slot_d[i][EW-1 -: PRIO_W];
        end
    end

    // Storage update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
            cnt_q  <= '0;
        end else begin
            slot_q <= slot_d;
            cnt_q  <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/pifo_range_table.sv
// Range table: registered lowest/highest priority and occupancy of each bank,
// loaded from the banks' next state. Searches it with a probe priority and
// flags every occupied bank whose highest priority is above the probe.
// Assumes the nxt_* inputs describe the contents after the current edge.
module pifo_range_table #(
    parameter int NUM_BANKS = 8,
    parameter int PRIO_W    = 16,
    parameter int CW        = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_BANKS-1:0][CW-1:0]     nxt_cnt_i,
    input  logic [NUM_BANKS-1:0][PRIO_W-1:0] nxt_min_i,
    input  logic [NUM_BANKS-1:0][PRIO_W-1:0] nxt_max_i,
    input  logic [PRIO_W-1:0]                probe_i,
    output logic [NUM_BANKS-1:0][PRIO_W-1:0] min_o,
    output logic [NUM_BANKS-1:0][PRIO_W-1:0] max_o,
    output logic [NUM_BANKS-1:0]             nonempty_o,
    output logic [NUM_BANKS-1:0]             above_o
);
    // Table registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            min_o      <= '0;
            max_o      <= '0;
            nonempty_o <= '0;
        end else begin
            min_o <= nxt_min_i;
            max_o <= nxt_max_i;
            for (int b = 0; b < NUM_BANKS; b++)
                nonempty_o[b] <= (nxt_cnt_i[b] != '0);
        end
    end

    // Range search, one comparator per bank.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_match
        assign above_o[b] = nonempty_o[b] && (probe_i < max_o[b]);
    end
endmodule

// File: rtl/pifo_ctrl.sv
// Insert/pop control. Picks the target bank and slot from the range search,
// then plans a ripple toward the nearest bank with room: forward (tails move
// to the next bank's head) or, when no later bank has room, backward (heads
// move to the previous bank's tail). Pop outranks insert.
// Assumes occupied banks hold ascending, non-overlapping ranges by index.
module pifo_ctrl
    import pifo_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int DEPTH     = 8,
    parameter int EW        = 24,
    parameter int CW        = 4,
    localparam int BIW      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                      ins_valid_i,
    input  logic                      pop_i,
    input  logic [EW-1:0]             item_i,
    input  logic [NUM_BANKS-1:0]      above_i,
    input  logic [NUM_BANKS-1:0]      nonempty_i,
    input  logic [NUM_BANKS-1:0][CW-1:0] cnt_i,
    input  logic [NUM_BANKS-1:0][CW-1:0] le_cnt_i,
    input  logic [NUM_BANKS-1:0][EW-1:0] head_i,
    input  logic [NUM_BANKS-1:0][EW-1:0] tail_i,
    output bank_op_e                  op_o [NUM_BANKS],
    output logic [NUM_BANKS-1:0][CW-1:0] pos_o,
    output logic [NUM_BANKS-1:0][EW-1:0] item_o,
    output logic                      accept_o,
    output logic                      pop_ok_o,
    output logic [BIW-1:0]            pop_bank_o
);
    int            k, j, i, f, last;
    logic [CW-1:0] p;
    logic          has_match;
    logic [NUM_BANKS-1:0] bfull;

    // Bank-full flags.
    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++) bfull[b] = (cnt_i[b] == CW'(DEPTH));
    end

    // Target selection and ripple planning.
    always_comb begin
        f = 0;
        for (int b = NUM_BANKS - 1; b >= 0; b--) if (nonempty_i[b]) f = b;
        pop_ok_o   = pop_i && (|nonempty_i);
        pop_bank_o = BIW'(f);

        has_match = 1'b0;
        k = 0;
        for (int b = NUM_BANKS - 1; b >= 0; b--) begin
            if (above_i[b]) begin
                has_match = 1'b1;
                k = b;
            end
        end
        last = 0;
        for (int b = 0; b < NUM_BANKS; b++) if (nonempty_i[b]) last = b;

        if (has_match)                     p = le_cnt_i[k];
        else if (!(|nonempty_i)) begin     k = 0;        p = '0;          end
        else if (!bfull[last]) begin       k = last;     p = cnt_i[last]; end
        else if (last < NUM_BANKS - 1) begin k = last + 1; p = '0;        end
        else begin                         k = last;     p = CW'(DEPTH);  end

        j = -1;
        for (int b = NUM_BANKS - 1; b >= 0; b--) if (b > k && !bfull[b]) j = b;
        i = -1;
        for (int b = 0; b < NUM_BANKS; b++) if (b < k && !bfull[b]) i = b;

        accept_o = ins_valid_i && !pop_i && (!bfull[k] || j >= 0 || i >= 0);

        for (int b = 0; b < NUM_BANKS; b++) begin
            op_o[b]   = BOP_HOLD;
            pos_o[b]  = '0;
            item_o[b] = '0;
        end

        if (pop_ok_o) begin
            op_o[f] = BOP_POP;
        end else if (accept_o && !bfull[k]) begin
            op_o[k]   = BOP_INS;
            pos_o[k]  = p;
            item_o[k] = item_i;
        end else if (accept_o && j >= 0) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (b == k) begin
                    op_o[b] = BOP_INS_DROPT; pos_o[b] = p; item_o[b] = item_i;
                end else if (b > k && b <= j) begin
                    op_o[b]   = (b == j) ? BOP_INS : BOP_INS_DROPT;
                    item_o[b] = tail_i[(b > 0) ? b - 1 : 0];
                end
            end
        end else if (accept_o) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (b == k) begin
                    op_o[b] = BOP_INS_DROPH; pos_o[b] = p; item_o[b] = item_i;
                end else if (b >= i && b < k) begin
                    op_o[b]  = (b == i) ? BOP_INS : BOP_INS_DROPH;
                    pos_o[b] = (b == i) ? cnt_i[b] : CW'(DEPTH);
                    if (b + 1 == k)
                        item_o[b] = (p == '0) ? item_i : head_i[k];
                    else
                        item_o[b] = head_i[(b < NUM_BANKS - 1) ? b + 1 : b];
                end
            end
        end
    end
endmodule

// File: rtl/pifo_banked.sv
// Top: banked sorted priority queue. Ties the banks, the range table and the
// controller together and registers the pop result and the insert reject.
// Assumes one request type per cycle is served; a pop wins a collision.
module pifo_banked
    import pifo_pkg::*;
#(
    parameter int NUM_BANKS  = 8,
    parameter int BANK_DEPTH = 8,
    parameter int PRIO_W     = 16,
    parameter int TAG_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid_i,
    input  logic [PRIO_W-1:0] ins_prio_i,
    input  logic [TAG_W-1:0]  ins_tag_i,
    input  logic              pop_i,
    output logic              ins_reject_o,
    output logic              pop_valid_o,
    output logic [PRIO_W-1:0] pop_prio_o,
    output logic [TAG_W-1:0]  pop_tag_o,
    output logic              pop_empty_o,
    output logic              empty_o,
    output logic              full_o
);
    localparam int EW  = PRIO_W + TAG_W;
    localparam int CW  = $clog2(BANK_DEPTH + 1);
    localparam int BIW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    logic [NUM_BANKS-1:0][CW-1:0]     b_cnt, b_le, b_pos, b_nxt_cnt;
    logic [NUM_BANKS-1:0][EW-1:0]     b_head, b_tail, b_item;
    logic [NUM_BANKS-1:0][PRIO_W-1:0] b_nmin, b_nmax;
    bank_op_e                         b_op [NUM_BANKS];
    logic [NUM_BANKS-1:0][PRIO_W-1:0] rng_min, rng_max;
    logic [NUM_BANKS-1:0]             rng_ne, rng_above;
    logic                             accept, pop_ok;
    logic [BIW-1:0]                   pop_bank;
    logic [EW-1:0]                    new_item;

    assign new_item = {ins_prio_i, ins_tag_i};

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        pifo_bank #(.DEPTH(BANK_DEPTH), .PRIO_W(PRIO_W), .TAG_W(TAG_W)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .op_i      (b_op[b]),
            .pos_i     (b_pos[b]),
            .item_i    (b_item[b]),
            .probe_i   (ins_prio_i),
            .le_cnt_o  (b_le[b]),
            .cnt_o     (b_cnt[b]),
            .head_o    (b_head[b]),
            .tail_o    (b_tail[b]),
            .nxt_cnt_o (b_nxt_cnt[b]),
            .nxt_min_o (b_nmin[b]),
            .nxt_max_o (b_nmax[b])
        );
    end

    pifo_range_table #(.NUM_BANKS(NUM_BANKS), .PRIO_W(PRIO_W), .CW(CW)) u_rng (
        .clk        (clk),
        .rst_n      (rst_n),
        .nxt_cnt_i  (b_nxt_cnt),
        .nxt_min_i  (b_nmin),
        .nxt_max_i  (b_nmax),
        .probe_i    (ins_prio_i),
        .min_o      (rng_min),
        .max_o      (rng_max),
        .nonempty_o (rng_ne),
        .above_o    (rng_above)
    );

    pifo_ctrl #(.NUM_BANKS(NUM_BANKS), .DEPTH(BANK_DEPTH), .EW(EW), .CW(CW)) u_ctrl (
        .ins_valid_i (ins_valid_i),
        .pop_i       (pop_i),
        .item_i      (new_item),
        .above_i     (rng_above),
        .nonempty_i  (rng_ne),
        .cnt_i       (b_cnt),
        .le_cnt_i    (b_le),
        .head_i      (b_head),
        .tail_i      (b_tail),
        .op_o        (b_op),
        .pos_o       (b_pos),
        .item_o      (b_item),
        .accept_o    (accept),
        .pop_ok_o    (pop_ok),
        .pop_bank_o  (pop_bank)
    );

    // Registered responses to the requests of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ins_reject_o <= 1'b0;
            pop_valid_o  <= 1'b0;
            pop_prio_o   <= '0;
            pop_tag_o    <= '0;
            pop_empty_o  <= 1'b0;
        end else begin
            ins_reject_o <= ins_valid_i && !accept;
            pop_valid_o  <= pop_ok;
            pop_prio_o   <= pop_ok ? rng_min[pop_bank] : '0;
            pop_tag_o    <= pop_ok ? b_head[pop_bank][TAG_W-1:0] : '0;
            pop_empty_o  <= pop_i && !(|rng_ne);
        end
    end

    // Occupancy flags from the registered state.
    always_comb begin
        empty_o = !(|rng_ne);
        full_o  = 1'b1;
        for (int b = 0; b < NUM_BANKS; b++)
            if (b_cnt[b] != CW'(BANK_DEPTH)) full_o = 1'b0;
    end
endmodule

// File: rtl/pifo_banked_checker.sv
// Property checker for pifo_banked, attached by bind below.
// Assumes the bound signals carry the top's registered range table.
module pifo_banked_checker #(
    parameter int NUM_BANKS = 8,
    parameter int PRIO_W    = 16
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          ins_valid_i,
    input logic                          pop_i,
    input logic                          ins_reject_o,
    input logic                          pop_valid_o,
    input logic                          pop_empty_o,
    input logic                          empty_o,
    input logic                          full_o,
    input logic [NUM_BANKS-1:0][PRIO_W-1:0] rng_min,
    input logic [NUM_BANKS-1:0][PRIO_W-1:0] rng_max,
    input logic [NUM_BANKS-1:0]             rng_ne
);
    logic             order_ok;
    logic [PRIO_W-1:0] seen_max;

    // Occupied banks must hold ascending, non-overlapping ranges.
    always_comb begin
        order_ok = 1'b1;
        seen_max = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (rng_ne[b]) begin
                if (rng_min[b] < seen_max || rng_min[b] > rng_max[b]) order_ok = 1'b0;
                seen_max = rng_max[b];
            end
        end
    end

    assert_bank_order_R6: assert property (@(posedge clk) disable iff (!rst_n) order_ok);
    assert_pop_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !empty_o) |=> pop_valid_o);
    assert_empty_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && empty_o) |=> (pop_empty_o && !pop_valid_o));
    assert_reject_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid_i && full_o) |=> ins_reject_o);
    assert_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty_o && full_o));
    assert_collision_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid_i && pop_i) |=> ins_reject_o);
    assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid_i && !pop_i && !full_o) |=> !ins_reject_o);
endmodule

bind pifo_banked pifo_banked_checker #(.NUM_BANKS(NUM_BANKS), .PRIO_W(PRIO_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ins_valid_i  (ins_valid_i),
    .pop_i        (pop_i),
    .ins_reject_o (ins_reject_o),
    .pop_valid_o  (pop_valid_o),
    .pop_empty_o  (pop_empty_o),
    .empty_o      (empty_o),
    .full_o       (full_o),
    .rng_min      (rng_min),
    .rng_max      (rng_max),
    .rng_ne       (rng_ne)
);

// File: tb/pifo_banked_test.sv
// Directed bench for pifo_banked with a sorted reference list.
module pifo_banked_test;
    localparam int CAP = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ins_valid_i = 1'b0;
    logic [15:0] ins_prio_i = '0;
    logic [7:0]  ins_tag_i = '0;
    logic        pop_i = 1'b0;
    logic        ins_reject_o, pop_valid_o, pop_empty_o, empty_o, full_o;
    logic [15:0] pop_prio_o;
    logic [7:0]  pop_tag_o;

    int n_checks = 0;
    int n_fail   = 0;
    int m_prio [CAP];
    int m_tag  [CAP];
    int m_n    = 0;

    pifo_banked uut (
        .clk(clk), .rst_n(rst_n), .ins_valid_i(ins_valid_i), .ins_prio_i(ins_prio_i),
        .ins_tag_i(ins_tag_i), .pop_i(pop_i), .ins_reject_o(ins_reject_o),
        .pop_valid_o(pop_valid_o), .pop_prio_o(pop_prio_o), .pop_tag_o(pop_tag_o),
        .pop_empty_o(pop_empty_o), .empty_o(empty_o), .full_o(full_o)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reference: stable insert after equal priorities.
    task automatic model_push(input int pr, input int tg);
        int at = m_n;
        for (int q = 0; q < m_n; q++) begin
            if (m_prio[q] > pr) begin at = q; break; end
        end
        for (int q = m_n; q > at; q--) begin
            m_prio[q] = m_prio[q-1];
            m_tag[q]  = m_tag[q-1];
        end
        m_prio[at] = pr;
        m_tag[at]  = tg;
        m_n++;
    endtask

    task automatic model_pop();
        for (int q = 0; q < m_n - 1; q++) begin
            m_prio[q] = m_prio[q+1];
            m_tag[q]  = m_tag[q+1];
        end
        m_n--;
    endtask

    // One insert cycle; result sampled at the following falling edge.
    task automatic do_ins(input int pr, input int tg, input string req);
        @(negedge clk);
        ins_valid_i = 1'b1; ins_prio_i = 16'(pr); ins_tag_i = 8'(tg);
        @(negedge clk);
        ins_valid_i = 1'b0;
        if (m_n < CAP) begin
            check(ins_reject_o == 1'b0, req, int'(ins_reject_o), 0);
            model_push(pr, tg);
        end else begin
            check(ins_reject_o == 1'b1, req, int'(ins_reject_o), 1);
        end
    endtask

    task automatic do_pop_check(input string req);
        @(negedge clk);
        pop_i = 1'b1;
        @(negedge clk);
        pop_i = 1'b0;
        if (m_n == 0) begin
            check(pop_empty_o && !pop_valid_o, "R4", int'(pop_valid_o), 0);
            check(pop_prio_o == '0 && pop_tag_o == '0, "R4", int'(pop_prio_o), 0);
        end else begin
            check(pop_valid_o == 1'b1, req, int'(pop_valid_o), 1);
            check(int'(pop_prio_o) == m_prio[0], req, int'(pop_prio_o), m_prio[0]);
            check(int'(pop_tag_o) == m_tag[0], req, int'(pop_tag_o), m_tag[0]);
            model_pop();
        end
    endtask

    task automatic drain(input string req);
        while (m_n > 0) do_pop_check(req);
        check(empty_o == 1'b1, req, int'(empty_o), 1);
    endtask

    task automatic t_reset_state();
        check(empty_o == 1'b1, "R1", int'(empty_o), 1);
        check(full_o == 1'b0, "R1", int'(full_o), 0);
        check(pop_valid_o == 1'b0 && pop_empty_o == 1'b0, "R1", int'(pop_valid_o), 0);
        check(ins_reject_o == 1'b0, "R1", int'(ins_reject_o), 0);
    endtask

    task automatic t_pop_empty();
        do_pop_check("R4");
        check(empty_o == 1'b1, "R4", int'(empty_o), 1);
    endtask

    task automatic t_mixed();
        for (int n = 0; n < 20; n++) begin
            do_ins(100 + (n * 37) % 50, n, "R8");
            if (n == 0) check(empty_o == 1'b0, "R8", int'(empty_o), 0);
        end
        drain("R2");
    endtask

    task automatic t_ties();
        for (int n = 0; n < 12; n++) do_ins((n % 3 == 0) ? 9 : ((n % 3 == 1) ? 5 : 3), 40 + n, "R3");
        drain("R3");
    endtask

    task automatic t_below_all();
        for (int n = 0; n < 10; n++) do_ins(1000 + n * 10, n, "R9");
        do_ins(7, 99, "R9");
        do_pop_check("R9");
        drain("R9");
    endtask

    task automatic t_fill_reject();
        for (int n = 0; n < CAP; n++) do_ins(((n * 29) % 64) * 3, n, "R6");
        check(full_o == 1'b1, "R5", int'(full_o), 1);
        do_ins(1, 200, "R5");
        check(full_o == 1'b1, "R5", int'(full_o), 1);
        drain("R5");
    endtask

    task automatic t_backward();
        for (int n = 0; n < CAP; n++) do_ins(n * 4, n, "R6");
        for (int n = 0; n < 16; n++) do_pop_check("R6");
        for (int n = 0; n < 16; n++) do_ins((n % 2 == 0) ? 2000 + n : 130 + n * 8 + 1, 100 + n, "R6");
        check(full_o == 1'b1, "R6", int'(full_o), 1);
        drain("R6");
    endtask

    task automatic t_collision();
        do_ins(50, 7, "R7");
        @(negedge clk);
        ins_valid_i = 1'b1; ins_prio_i = 16'd10; ins_tag_i = 8'd8; pop_i = 1'b1;
        @(negedge clk);
        ins_valid_i = 1'b0; pop_i = 1'b0;
        check(ins_reject_o == 1'b1, "R7", int'(ins_reject_o), 1);
        check(pop_valid_o && int'(pop_prio_o) == 50, "R7", int'(pop_prio_o), 50);
        model_pop();
        check(empty_o == 1'b1, "R7", int'(empty_o), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_pop_empty();
        t_mixed();
        t_ties();
        t_below_all();
        t_fill_reject();
        t_backward();
        t_collision();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule